// File: doc/BRIEF.md
# Serial Audio Output Transmitter

This block turns pairs of parallel PCM samples (left and right, 20 bits each) into a three-wire serial audio stream. The three wires are a bit clock, a data line and a word-select line. The bit clock is a register in the system-clock domain. A programmable counter derives it, and its period is always an even number of system cycles. Every frame carries the left sample first and then the right sample.

Two slot formats are supported:

- **Narrow format:** each channel slot is 16 bit clocks long and carries the upper 16 bits of the sample.
- **Wide format:** each slot is 32 bit clocks long. It carries all 20 sample bits from the MSB down, followed by twelve zero bits.

Two further options can be set independently of each other:

- The word-select line can be inverted.
- The data can be delayed by one bit clock, which gives the I2S-style alignment.

A one-entry buffer takes samples through a valid/ready handshake. A frame sequencer drains the buffer at each frame start. The sequencer has four named states:

- `ST_IDLE`: after reset, before the first falling bit-clock edge.
- `ST_LEFT`: left slot.
- `ST_RIGHT`: right slot.
- `ST_BAD`: an unreachable encoding that recovers to `ST_IDLE`.

Its transitions are:

- **IDLE→LEFT:** on the first falling edge. This is a frame start.
- **LEFT→RIGHT:** on the falling edge that ends the last bit of the left slot.
- **RIGHT→LEFT:** on the falling edge that ends the last bit of the right slot. This is also a frame start.
- **BAD→IDLE:** recovery from the unreachable encoding.

If the buffer is empty at a frame start, both slots of that frame are sent as zeros and a sticky underrun flag is raised.

Top module: `pcm_serial_tx`

## Requirements
- R1: The bit clock `bclk` has a period of exactly 2*(`cfg_half`+1) system clock cycles with equal high and low phases. The divider value follows `cfg_half` while idle and is re-sampled at every frame start.
- R2: With `cfg_wide`=0, each slot lasts 16 bit clocks and carries input bits 19 down to 4, MSB first.
- R3: With `cfg_wide`=1, each slot lasts 32 bit clocks and carries input bits 19 down to 0, MSB first, followed by 12 zero bits.
- R4: Each frame sends the left slot, then the right slot. With `cfg_ws_inv`=0, `ws` is 0 during the left slot and 1 during the right slot. With `cfg_ws_inv`=1, both levels are complemented.
- R5: With `cfg_delay`=1, `sd` lags `ws` by one bit clock: the first bit time of every slot carries the final bit of the preceding slot. In the first frame after reset, that bit is 0.
- R6: `sd` and `ws` change only in the system cycle in which `bclk` falls. They are therefore stable across every rising edge of `bclk`.
- R7: `in_ready` is 1 exactly when the one-entry buffer is empty. A pair is accepted on a clock edge with `in_valid` and `in_ready` both high. The buffer is emptied at each frame start.
- R8: If the buffer is empty at a frame start, both slots of that frame carry zeros and `underrun` is set to 1. `underrun` then stays 1 until an `underrun_clr` pulse. A new underrun in the same cycle as the clear wins over the clear.
- R9: `cfg_wide`, `cfg_ws_inv`, `cfg_delay` and `cfg_half` are taken into use only at a frame start (or while idle after reset). A change in the middle of a frame leaves that frame unchanged.
- R10: After reset, `bclk` and `sd` are 0, `underrun` is 0, and `ws` sits at its right-slot level. The first falling edge of `bclk` starts a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 1 selects 32-bit slots, 0 selects 16-bit slots |
| cfg_ws_inv | input | 1 | Invert the word-select level |
| cfg_delay | input | 1 | Delay data by one bit clock relative to word select |
| cfg_half | input | DIV_W | Half bit-clock period minus one, in system cycles |
| in_valid | input | 1 | Sample pair present |
| in_ready | output | 1 | Buffer empty, pair can be accepted |
| in_left | input | SAMPLE_W | Left sample, MSB aligned |
| in_right | input | SAMPLE_W | Right sample, MSB aligned |
| underrun_clr | input | 1 | Pulse to clear the underrun flag |
| bclk | output | 1 | Serial bit clock |
| ws | output | 1 | Word-select line |
| sd | output | 1 | Serial data line |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bit clock, the data line and the word-select line all move in the same system cycle: the cycle in which `bclk` goes from 1 to 0. The bench therefore samples `sd` and `ws` at each rising edge of `bclk`, half a bit period after they change, in the same way a serial receiver would. It compares the captured stream bit by bit with a stream built arithmetically from the pushed samples. In delay mode, that stream is shifted by one position.

The underrun flag is set on the falling edge that starts the empty frame. A clear takes effect on the next system edge. For that reason the bench probes and clears the flag only in the middle of a slot, far from any frame start. It reads `in_ready` one system cycle after each accepted handshake.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEFT  = 2'd1,
        ST_RIGHT = 2'd2,
        ST_BAD   = 2'd3
    } sat_state_e;

    typedef struct packed {
        logic wide;
        logic ws_inv;
        logic delay;
    } sat_cfg_t;

endpackage

// File: rtl/sat_bclk_gen.sv
module sat_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             frame_load,
    input  logic [DIV_W-1:0] half_in,
    output logic             bclk,
    output logic             fall_evt
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] half_eff;
    logic             bclk_q;
    logic             hit;

    assign half_eff = idle ? half_in : half_q;
    assign hit      = (cnt_q >= half_eff);
    assign fall_evt = hit && bclk_q;
    assign bclk     = bclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            half_q <= '0;
            bclk_q <= 1'b0;
        end else begin
            if (idle || frame_load) begin
                half_q <= half_in;
            end
            if (hit) begin
                cnt_q  <= '0;
                bclk_q <= ~bclk_q;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // R1: the divider count never runs past the active half period
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !frame_load && $stable(half_q)) |-> (cnt_q <= half_q));

endmodule

// File: rtl/sat_sample_buf.sv
module sat_sample_buf #(
    parameter int SAMPLE_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                take,
    output logic                in_ready,
    output logic                full,
    output logic [SAMPLE_W-1:0] left,
    output logic [SAMPLE_W-1:0] right
);
    logic full_q;
    logic accept;

    assign in_ready = ~full_q;
    assign full     = full_q;
    assign accept   = in_valid && ~full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            left   <= '0;
            right  <= '0;
        end else if (accept) begin
            full_q <= 1'b1;
            left   <= in_left;
            right  <= in_right;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    assert_accept_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (full && !in_ready));

    assert_take_drains_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full) |=> in_ready);

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
    parameter int SAMPLE_W = 20,
    parameter int DIV_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wide,
    input  logic                cfg_ws_inv,
    input  logic                cfg_delay,
    input  logic [DIV_W-1:0]    cfg_half,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                underrun_clr,
    output logic                bclk,
    output logic                ws,
    output logic                sd
,
    output logic                underrun
);
    import sat_pkg::*;

    localparam int NARROW_SLOT = 16;
    localparam int WIDE_SLOT   = 32;
    localparam int NARROW_BITS = (SAMPLE_W < NARROW_SLOT) ? SAMPLE_W : NARROW_SLOT;
    localparam int WIDE_BITS   = (SAMPLE_W < WIDE_SLOT) ? SAMPLE_W : WIDE_SLOT;
    localparam int KW          = $clog2(WIDE_SLOT);
    localparam logic [KW-1:0] NARROW_LAST = KW'(NARROW_SLOT - 1);
    localparam logic [KW-1:0] WIDE_LAST   = KW'(WIDE_SLOT - 1);

    sat_state_e          state_q, state_d;
    logic [KW-1:0]       k_q, k_d;
    sat_cfg_t            cfg_q;
    logic [SAMPLE_W-1:0] cur_l, cur_r;
    logic                tail_q;
    logic                underrun_q;
    logic                fall_evt;
    logic                buf_full;
    logic [SAMPLE_W-1:0] buf_l, buf_r;
    logic                slot_last;
    logic                frame_load;
    logic                take;
    logic                idle;
    logic                ws_c, sd_c;

    function automatic logic slot_bit(input logic [SAMPLE_W-1:0] s, input int idx, input logic wide);
        int bound;
        bound = wide ? WIDE_BITS : NARROW_BITS;
        if (idx >= 0 && idx < bound) begin
            return s[SAMPLE_W-1-idx];
        end
        return 1'b0;
    endfunction

    assign idle       = (state_q == ST_IDLE);
    assign slot_last  = (k_q == (cfg_q.wide ? WIDE_LAST : NARROW_LAST));
    assign frame_load = fall_evt && (idle || (state_q == ST_RIGHT && slot_last));
    assign take       = frame_load && buf_full;

    sat_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (idle),
        .frame_load (frame_load),
        .half_in    (cfg_half),
        .bclk       (bclk),
        .fall_evt   (fall_evt)
    );

    sat_sample_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_left  (in_left),
        .in_right (in_right),
        .take     (take),
        .in_ready (in_ready),
        .full     (buf_full),
        .left     (buf_l),
        .right    (buf_r)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        k_d     = k_q;
        if (fall_evt) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_LEFT;
                    k_d     = '0;
                end
                ST_LEFT: begin
                    if (slot_last) begin
                        state_d = ST_RIGHT;
                        k_d     = '0;
                    end else begin
                        k_d = k_q + 1'b1;
                    end
                end
                ST_RIGHT: begin
                    if (slot_last) begin
                        state_d = ST_LEFT;
                        k_d     = '0;
                    end else begin
                        k_d = k_q + 1'b1;
                    end
                end
                ST_BAD: begin
                    state_d = ST_IDLE;
                    k_d     = '0;
                end
            endcase
        end
    end

    // state register and frame data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            k_q        <= '0;
            cfg_q      <= '0;
            cur_l      <= '0;
            cur_r      <= '0;
            tail_q     <= 1'b0;
            underrun_q <= 1'b0;
        end else begin
            state_q <= state_d;
            k_q     <= k_d;
            if (idle || frame_load) begin
                cfg_q <= '{wide: cfg_wide, ws_inv: cfg_ws_inv, delay: cfg_delay};
            end
            if (frame_load) begin
                tail_q <= idle ? 1'b0
                               : slot_bit(cur_r, (cfg_q.wide ? WIDE_SLOT : NARROW_SLOT) - 1, cfg_q.wide);
                cur_l  <= buf_full ? buf_l : '0;
                cur_r  <= buf_full ? buf_r : '0;
            end
            if (frame_load && !buf_full) begin
                underrun_q <= 1'b1;
            end else if (underrun_clr) begin
                underrun_q <= 1'b0;
            end
        end
    end

    // output logic
    always_comb begin
        ws_c = ~cfg_q.ws_inv;
        sd_c = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_BAD: begin
                ws_c = ~cfg_q.ws_inv;
                sd_c = 1'b0;
            end
            ST_LEFT: begin
                ws_c = cfg_q.ws_inv;
                if (cfg_q.delay) begin
                    sd_c = (k_q == '0) ? tail_q : slot_bit(cur_l, int'(k_q) - 1, cfg_q.wide);
                end else begin
                    sd_c = slot_bit(cur_l, int'(k_q), cfg_q.wide);
                end
            end
            ST_RIGHT: begin
                ws_c = ~cfg_q.ws_inv;
                if (cfg_q.delay) begin
                    sd_c = (k_q == '0)
                         ? slot_bit(cur_l, (cfg_q.wide ? WIDE_SLOT : NARROW_SLOT) - 1, cfg_q.wide)
                         : slot_bit(cur_r, int'(k_q) - 1, cfg_q.wide);
                end else begin
                    sd_c = slot_bit(cur_r, int'(k_q), cfg_q.wide);
                end
            end
        endcase
    end

    assign ws       = ws_c;
    assign sd       = sd_c;
    assign underrun = underrun_q;

    assert_sd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_evt && !idle) |=> $stable(sd));

    assert_ws_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_evt && !idle) |=> $stable(ws));

    assert_frame_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (state_q == ST_LEFT && k_q == '0 && !bclk));

    assert_underrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_load && !buf_full) |=> underrun);

    assert_k_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (k_q <= (cfg_q.wide ? WIDE_LAST : NARROW_LAST)));

endmodule

// File: tb/pcm_serial_tx_test.sv
module pcm_serial_tx_test;

    localparam int SW    = 20;
    localparam int DW    = 8;
    localparam int NFR   = 6;
    localparam int NDATA = 3;
    localparam int MAXB  = NFR * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wide = 1'b0, cfg_ws_inv = 1'b0, cfg_delay = 1'b0;
    logic [DW-1:0] cfg_half = 8'd1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] in_left = '0, in_right = '0;
    logic          underrun_clr = 1'b0;
    logic          bclk, ws, sd, underrun;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic sd_cap [MAXB];
    logic ws_cap [MAXB];
    int   rise_t [MAXB];

    always #4 clk = ~clk;

    pcm_serial_tx #(.SAMPLE_W(SW), .DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_ws_inv(cfg_ws_inv),
        .cfg_delay(cfg_delay), .cfg_half(cfg_half), .in_valid(in_valid),
        .in_ready(in_ready), .in_left(in_left), .in_right(in_right),
        .underrun_clr(underrun_clr), .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] samp(input int run, input int f, input int ch);
        logic [31:0] h;
        h = 32'((run * 8 + f * 2 + ch + 1)) * 32'h9E3779B9;
        return h[31:12];
    endfunction

    function automatic logic base_bit(input int run, input int g, input bit wide);
        int s, f, pos, k;
        logic [SW-1:0] v;
        s   = wide ? 32 : 16;
        f   = g / (2 * s);
        pos = g % (2 * s);
        k   = pos % s;
        if (f >= NDATA) return 1'b0;
        v = samp(run, f, (pos >= s) ? 1 : 0);
        if (k < (wide ? 20 : 16)) return v[SW-1-k];
        return 1'b0;
    endfunction

    task automatic push_all(input int run);
        for (int f = 0; f < NDATA; f++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_left  = samp(run, f, 0);
            in_right = samp(run, f, 1);
            while (!in_ready) @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check(in_ready == 1'b0, "R7 ready drops after accept", in_ready, 0);
        end
    endtask

    task automatic capture(input int run, input bit wide, input bit inv, input int half);
        int  s, g, edge_err;
        bit  prev_b, prev_sd, prev_ws, clr_pend;
        s = wide ? 32 : 16;
        @(negedge clk);
        check(bclk == 1'b0 && sd == 1'b0 && underrun == 1'b0, "R10 reset outputs",
              {bclk, sd, underrun}, 0);
        check(ws == ~inv, "R10 idle ws level", ws, ~inv);
        prev_b = bclk;
        forever begin
            @(negedge clk);
            cyc++;
            if (prev_b && !bclk) break;
            prev_b = bclk;
        end
        check(ws == inv, "R10 first slot is left", ws, inv);
        prev_b = bclk; prev_sd = sd; prev_ws = ws;
        g = 0; edge_err = 0; clr_pend = 0;
        while (g < NFR * 2 * s) begin
            @(negedge clk);
            cyc++;
            if (clr_pend) begin
                underrun_clr = 1'b0;
                clr_pend = 0;
                check(underrun == 1'b0, "R8 clear", underrun, 0);
            end
            if ((sd != prev_sd || ws != prev_ws) && !(prev_b && !bclk)) edge_err++;
            if (!prev_b && bclk) begin
                sd_cap[g] = sd;
                ws_cap[g] = ws;
                rise_t[g] = cyc;
                if (g == 2 * s + s / 2) cfg_ws_inv = ~inv;
                if (g == 2 * 2 * s + s / 2) check(underrun == 1'b0, "R8 no underrun yet", underrun, 0);
                if (g == 3 * 2 * s + s / 2) check(underrun == 1'b1, "R8 underrun set", underrun, 1);
                if (g == 4 * 2 * s + s / 2) begin
                    underrun_clr = 1'b1;
                    clr_pend = 1;
                end
                if (g == 5 * 2 * s + s / 2) check(underrun == 1'b1, "R8 underrun sets again", underrun, 1);
                g++;
            end
            prev_b = bclk; prev_sd = sd; prev_ws = ws;
        end
        check(edge_err == 0, "R6 changes only at falling bclk", edge_err, 0);
        check(rise_t[2] - rise_t[1] == 2 * (half + 1), "R1 bit clock period",
              rise_t[2] - rise_t[1], 2 * (half + 1));
    endtask

    task automatic run_case(input int run, input bit wide, input bit inv, input bit dly, input int half);
        int s;
        s = wide ? 32 : 16;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_wide = wide; cfg_ws_inv = inv; cfg_delay = dly; cfg_half = DW'(half);
        in_valid = 1'b0; underrun_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            push_all(run);
            capture(run, wide, inv, half);
        join
        for (int f = 0; f < NFR; f++) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic [31:0] got_d, exp_d, got_w, exp_w;
                bit          inv_f;
                int          g0;
                string       tag;
                got_d = '0; exp_d = '0; got_w = '0; exp_w = '0;
                inv_f = (f >= 2) ? ~inv : inv;
                g0 = f * 2 * s + ch * s;
                for (int k = 0; k < s; k++) begin
                    int g;
                    logic eb;
                    g  = g0 + k;
                    eb = dly ? ((g == 0) ? 1'b0 : base_bit(run, g - 1, wide)) : base_bit(run, g, wide);
                    got_d[31-k] = sd_cap[g];
                    exp_d[31-k] = eb;
                    got_w[31-k] = ws_cap[g];
                    exp_w[31-k] = ch[0] ^ inv_f;
                end
                tag = (f >= NDATA) ? "R8 zero slot" : (wide ? "R3 wide slot" : "R2 narrow slot");
                if (dly) tag = {tag, " R5 delayed"};
                check(got_d == exp_d, $sformatf("%s run %0d frame %0d ch %0d", tag, run, f, ch), got_d, exp_d);
                check(got_w == exp_w,
                      $sformatf("%s run %0d frame %0d ch %0d", (f >= 2) ? "R9 R4 ws" : "R4 ws", run, f, ch),
                      got_w, exp_w);
            end
        end
    endtask

    initial begin
        int run;
        run = 0;
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 2; i++)
                for (int d = 0; d < 2; d++)
                    for (int h = 1; h <= 2; h++) begin
                        run_case(run, w[0], i[0], d[0], h);
                        run++;
                    end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule